// File: doc/BRIEF.md
# Parallel Flash Word/Byte Pin Front End

This block sits between the pins of a parallel NOR-style memory model and its internal command sequencer. It classifies the control pins (chip enable, output enable, write enable and a hardware reset, all active low) into one of several bus conditions: reset, standby, read, command write, output disabled, or the illegal case where output enable and write enable are both low. From that condition it drives the data-bus output enables and output data. It also captures write cycles and hands them to the sequencer.

A width-select input picks the bus width. When it is high, the full 16-bit data bus carries one word. When it is low, only the low byte lane is used, the middle pins float, and the top data pin becomes the least significant address bit. That bit selects one byte of the word that the sequencer returns. A write is taken from the bus on the rising edge of write enable or of chip enable, whichever comes first. It is handed over as a single-cycle strobe with a byte-granular address, the data and a width flag. The pins are assumed to be already synchronous to `clk`. The reset pin doubles as the asynchronous reset of the internal registers.

Top module: `fwb_bus_if`

## Requirements
- R1: With reset high, chip enable low, output enable low, write enable high and width-select high, `dq_oe` is all ones, `dq_out` equals `rd_word`, and `rd_addr` equals `addr`, in the same cycle.
- R2: Under the same read condition with width-select low, `dq_oe` is 16'h00FF and `dq_out[15:8]` is zero. `dq_out[7:0]` is `rd_word[7:0]` when `dq_in[15]` is 0 and `rd_word[15:8]` when `dq_in[15]` is 1.
- R3: With chip enable low and both output enable and write enable high, `dq_oe` and `dq_out` are zero.
- R4: With chip enable high, `dq_oe` and `dq_out` are zero whatever output enable and write enable do.
- R5: A write condition is chip enable low, write enable low and output enable high. Take the first clock at which that condition was present on the previous clock and now chip enable or write enable is high. On the clock after it, `seq_wr_stb` is high. The payload comes from the last clock of the write condition. `seq_wr_word` is the width-select value. `seq_wr_data` is `dq_in` in word mode and {8'h00, `dq_in[7:0]`} in byte mode. `seq_wr_addr` is {`addr`, 0} in word mode and {`addr`, `dq_in[15]`} in byte mode.
- R6: While reset is low, `dq_oe`, `dq_out` and `seq_wr_stb` are zero. A write cut short by reset produces no strobe after reset is released.
- R7: While chip enable, output enable and write enable are all low, `dq_oe` is zero. Any write in progress is dropped and gives no strobe, even when write enable later rises.
- R8: `seq_wr_stb` is never high on two clocks in a row. Back-to-back write cycles each give exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| hw_rst_n | input | 1 | Hardware reset pin, active low, also resets the registers asynchronously |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| word_sel | input | 1 | 1 = 16-bit word bus, 0 = byte bus |
| addr | input | AW | Word address pins |
| dq_in | input | DW | Data pins as seen by the block (bit 15 is the byte-lane address in byte mode) |
| dq_out | output | DW | Data driven onto the pins |
| dq_oe | output | DW | Per-pin output enable |
| rd_addr | output | AW | Read word address to the sequencer |
| rd_word | input | DW | Read word returned by the sequencer |
| seq_wr_stb | output | 1 | One-cycle write strobe to the sequencer |
| seq_wr_addr | output | AW+1 | Byte-granular write address |
| seq_wr_data | output | DW | Write data |
| seq_wr_word | output | 1 | Write was made in word mode |

## Verification
On every clock, the assertions check the following. Standby, output-disabled and reset keep all output enables low. Byte mode never enables the upper lane. A word read enables every pin. A strobe follows a rise of write enable or chip enable out of a write, keeps its payload stable and never repeats on the next clock. An illegal enable combination blocks the next strobe. Only the bench scenarios can show the exact byte chosen by the lane bit and the exact payload values. They also show that a write interrupted by reset or by the illegal condition stays lost once the pins return to a normal state.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [2:0] {
    BC_RESET,
    BC_STANDBY,
    BC_ILLEGAL,
    BC_WRITE,
    BC_READ,
    BC_OUTOFF
  } bus_cond_e;

  // Priority: reset, then deselect, then the clash of both strobes.
  function automatic bus_cond_e classify(input logic rst_n, input logic ce_n,
                                         input logic oe_n, input logic we_n);
    if (!rst_n)              return BC_RESET;
    else if (ce_n)           return BC_STANDBY;
    else if (!oe_n && !we_n) return BC_ILLEGAL;
    else if (!we_n)          return BC_WRITE;
    else if (!oe_n)          return BC_READ;
    else                     return BC_OUTOFF;
  endfunction

endpackage

// File: rtl/fwb_cond_decode.sv
module fwb_cond_decode
  import fwb_pkg::*;
(
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_live,
  output logic wr_live
);

  bus_cond_e cond;

  always_comb begin
    cond    = classify(rst_n, ce_n, oe_n, we_n);
    rd_live = (cond == BC_READ);
    wr_live = (cond == BC_WRITE);
  end

endmodule

// File: rtl/fwb_wr_capture.sv
module fwb_wr_capture #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_live,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          word_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic          stb,
  output logic [AW:0]   wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_word
);

  localparam int HB = DW / 2;

  function automatic logic [AW:0] byte_address(input logic [AW-1:0] a,
                                               input logic ws, input logic lane);
    return {a, ws ? 1'b0 : lane};
  endfunction

  function automatic logic [DW-1:0] lane_data(input logic [DW-1:0] d, input logic ws);
    return ws ? d : {{(DW-HB){1'b0}}, d[HB-1:0]};
  endfunction

  logic act_q;
  logic wr_end;   // rising edge of we_n or ce_n closing a write

  assign wr_end = act_q && (ce_n || we_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      stb     <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_word <= 1'b0;
    end else begin
      act_q <= wr_live;
      stb   <= wr_end;
      if (wr_live) begin
        wr_addr <= byte_address(addr, word_sel, dq_in[DW-1]);
        wr_data <= lane_data(dq_in, word_sel);
        wr_word <= word_sel;
      end
    end
  end

  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  // R5
  stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> $past(ce_n || we_n));

  // R5
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> ($stable(wr_addr) && $stable(wr_data) && $stable(wr_word)));

  // R7
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !we_n) |=> !stb);

endmodule

// File: rtl/fwb_rd_path.sv
module fwb_rd_path #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_live,
  input  logic          word_sel,
  input  logic          lane_hi,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe
);

  localparam int HB = DW / 2;

  function automatic logic [HB-1:0] pick_lane(input logic [DW-1:0] w, input logic hi);
    return hi ? w[DW-1:HB] : w[HB-1:0];
  endfunction

  logic [DW-1:0] pin_mask;
  logic [DW-1:0] pin_data;

  always_comb begin
    pin_mask = word_sel ? {DW{1'b1}} : {{(DW-HB){1'b0}}, {HB{1'b1}}};
    pin_data = word_sel ? rd_word : {{(DW-HB){1'b0}}, pick_lane(rd_word, lane_hi)};
    dq_oe    = rd_live ? pin_mask : '0;
    dq_out   = rd_live ? pin_data : '0;
  end

  // R2
  byte_upper_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_sel |-> (dq_oe[DW-1:HB] == '0));

endmodule

// File: rtl/fwb_bus_if.sv
module fwb_bus_if #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          hw_rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          word_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_word,
  output logic          seq_wr_stb,
  output logic [AW:0]   seq_wr_addr,
  output logic [DW-1:0] seq_wr_data,
  output logic          seq_wr_word
);

  logic rd_live;
  logic wr_live;

  assign rd_addr = addr;

  fwb_cond_decode u_dec (
    .rst_n   (hw_rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .rd_live (rd_live),
    .wr_live (wr_live)
  );

  fwb_rd_path #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst_n    (hw_rst_n),
    .rd_live  (rd_live),
    .word_sel (word_sel),
    .lane_hi  (dq_in[DW-1]),
    .rd_word  (rd_word),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  fwb_wr_capture #(.AW(AW), .DW(DW)) u_wr (
    .clk      (clk),
    .rst_n    (hw_rst_n),
    .wr_live  (wr_live),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .word_sel (word_sel),
    .addr     (addr),
    .dq_in    (dq_in),
    .stb      (seq_wr_stb),
    .wr_addr  (seq_wr_addr),
    .wr_data  (seq_wr_data),
    .wr_word  (seq_wr_word)
  );

  // R6
  always_ff @(posedge clk) begin
    if (!hw_rst_n) begin
      reset_quiet_chk: assert (dq_oe == '0 && !seq_wr_stb);
    end
  end

  // R4
  standby_float_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    ce_n |-> (dq_oe == '0));

  // R3
  outoff_float_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    oe_n |-> (dq_oe == '0));

  // R1
  word_read_drive_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (!ce_n && !oe_n && we_n && word_sel) |-> (&dq_oe));

endmodule

// File: tb/fwb_bus_if_tb.sv
module fwb_bus_if_tb;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          hw_rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, word_sel = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out, dq_oe, rd_word;
  logic [AW-1:0] rd_addr;
  logic          seq_wr_stb, seq_wr_word;
  logic [AW:0]   seq_wr_addr;
  logic [DW-1:0] seq_wr_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  // sequencer stand-in: read word is a scramble of the address
  function automatic logic [15:0] mem_word(input logic [19:0] a);
    logic [15:0] v;
    v = a[15:0] ^ {4{a[19:16]}} ^ 16'hA55A;
    return {v[7:0] + 8'd3, v[15:8]};
  endfunction

  assign rd_word = mem_word(rd_addr);

  fwb_bus_if #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .hw_rst_n(hw_rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .word_sel(word_sel), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .rd_addr(rd_addr), .rd_word(rd_word),
    .seq_wr_stb(seq_wr_stb), .seq_wr_addr(seq_wr_addr),
    .seq_wr_data(seq_wr_data), .seq_wr_word(seq_wr_word)
  );

  // reference model state
  bit          m_act = 0, m_stb = 0, m_word = 0;
  logic [AW:0] m_addr = '0;
  logic [15:0] m_data = '0;
  int          strobes = 0;

  always @(posedge clk) begin
    bit wnow;
    if (!hw_rst_n) begin
      m_act = 0; m_stb = 0; m_word = 0; m_addr = '0; m_data = '0;
    end else begin
      m_stb = m_act && (ce_n || we_n);
      wnow  = !ce_n && !we_n && oe_n;
      if (wnow) begin
        m_word = word_sel;
        m_addr = word_sel ? {addr, 1'b0} : {addr, dq_in[15]};
        m_data = word_sel ? dq_in : {8'h00, dq_in[7:0]};
      end
      m_act = wnow;
    end
    #5;
    compare();
  end

  task automatic compare();
    bit rd;
    logic [15:0] e_oe, e_out, w;
    string tag;
    rd = hw_rst_n && !ce_n && !oe_n && we_n;
    w  = mem_word(addr);
    if (!rd) begin e_oe = '0; e_out = '0; end
    else if (word_sel) begin e_oe = 16'hFFFF; e_out = w; end
    else begin e_oe = 16'h00FF; e_out = {8'h00, dq_in[15] ? w[15:8] : w[7:0]}; end
    if (!hw_rst_n) tag = "R6";
    else if (ce_n) tag = "R4";
    else if (!oe_n && !we_n) tag = "R7";
    else if (!we_n) tag = "R5";
    else if (oe_n) tag = "R3";
    else if (word_sel) tag = "R1";
    else tag = "R2";
    total++;
    if (dq_oe !== e_oe || dq_out !== e_out || (rd && rd_addr !== addr)) begin
      bad++;
      $display("FAIL %s pins: oe=%h out=%h raddr=%h expected oe=%h out=%h raddr=%h",
               tag, dq_oe, dq_out, rd_addr, e_oe, e_out, addr);
    end
    total++;
    if (seq_wr_stb !== m_stb ||
        (m_stb && (seq_wr_addr !== m_addr || seq_wr_data !== m_data || seq_wr_word !== m_word))) begin
      bad++;
      $display("FAIL %s strobe: stb=%b a=%h d=%h w=%b expected stb=%b a=%h d=%h w=%b",
               m_stb ? "R5" : "R8", seq_wr_stb, seq_wr_addr, seq_wr_data, seq_wr_word,
               m_stb, m_addr, m_data, m_word);
    end
    if (seq_wr_stb === 1'b1) strobes++;
  endtask

  task automatic drive(input bit r, input bit c, input bit o, input bit w, input bit ws,
                       input logic [AW-1:0] a, input logic [15:0] d, input int n);
    @(negedge clk);
    hw_rst_n = r; ce_n = c; oe_n = o; we_n = w; word_sel = ws; addr = a; dq_in = d;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic count_check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s strobe count: got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int s0;
    // R6 reset state with read-like pins
    drive(0, 0, 0, 1, 1, 20'h12345, 16'h0, 3);
    // R1 word reads
    drive(1, 0, 0, 1, 1, 20'h00000, 16'h0, 2);
    drive(1, 0, 0, 1, 1, 20'hFFFFF, 16'h0, 2);
    drive(1, 0, 0, 1, 1, 20'h5A5A5, 16'h0, 1);
    // R2 byte reads, both lanes
    drive(1, 0, 0, 1, 0, 20'h0ABCD, 16'h0000, 2);
    drive(1, 0, 0, 1, 0, 20'h0ABCD, 16'h8000, 2);
    drive(1, 0, 0, 1, 0, 20'h31337, 16'h7FFF, 1);
    // R3 output disabled, R4 standby with oe low and with we low
    drive(1, 0, 1, 1, 1, 20'h11111, 16'h0, 2);
    drive(1, 1, 0, 1, 1, 20'h22222, 16'h0, 2);
    drive(1, 1, 0, 0, 0, 20'h22222, 16'h0, 2);
    // R5 word write ended by we_n rise
    s0 = strobes;
    drive(1, 0, 1, 0, 1, 20'h0C0DE, 16'hBEEF, 3);
    drive(1, 0, 1, 1, 1, 20'h0C0DE, 16'hBEEF, 3);
    count_check("R5", strobes - s0, 1);
    // R5 byte write ended by ce_n rise, lane bit 1
    s0 = strobes;
    drive(1, 0, 1, 0, 0, 20'h00F0F, 16'h80A7, 2);
    drive(1, 1, 1, 0, 0, 20'h00F0F, 16'h0000, 3);
    count_check("R5", strobes - s0, 1);
    // R8 back-to-back writes
    s0 = strobes;
    drive(1, 0, 1, 0, 1, 20'h00001, 16'h1111, 1);
    drive(1, 0, 1, 1, 1, 20'h00002, 16'h2222, 1);
    drive(1, 0, 1, 0, 1, 20'h00003, 16'h3333, 1);
    drive(1, 0, 1, 1, 1, 20'h00004, 16'h4444, 3);
    count_check("R8", strobes - s0, 2);
    // R7 illegal aborts a write
    s0 = strobes;
    drive(1, 0, 1, 0, 1, 20'h0DEAD, 16'hCAFE, 2);
    drive(1, 0, 0, 0, 1, 20'h0DEAD, 16'hCAFE, 2);
    drive(1, 0, 1, 1, 1, 20'h0DEAD, 16'hCAFE, 3);
    count_check("R7", strobes - s0, 0);
    // R6 reset interrupts a write
    s0 = strobes;
    drive(1, 0, 1, 0, 0, 20'h00777, 16'h0055, 2);
    drive(0, 0, 1, 0, 0, 20'h00777, 16'h0055, 2);
    drive(1, 0, 1, 1, 0, 20'h00777, 16'h0055, 3);
    drive(0, 0, 1, 0, 1, 20'h00888, 16'h9999, 2);
    drive(1, 1, 1, 1, 1, 20'h00888, 16'h9999, 3);
    count_check("R6", strobes - s0, 0);
    // R1 read after all that
    drive(1, 0, 0, 1, 1, 20'h4321F, 16'h0, 2);
    drive(1, 1, 1, 1, 1, 20'h0, 16'h0, 2);
    done = 1;
    finish_run();
  end

endmodule